// File: doc/BRIEF.md
# Byte-to-18-bit-word address translator

This block maps a byte address onto storage that is packed as a dense array of 18-bit words, so that no bits of a 9/18-bit-wide memory are stranded. Each byte occupies eight consecutive bits of that array. Its first bit is at position 8·A. That position is divided by 18: the quotient is the index of the word holding the byte's first bit, and the remainder is the bit offset of that bit inside the word. A byte whose offset is above 10 runs past the end of its word and continues at bit 0 of the next word. A read-modify-write engine downstream uses the straddle flag and the two span lengths to split the byte into one or two partial-word updates.

No divider is used. The factor of 8 is a left shift. Dividing the position by 18 is rewritten as halving it and then dividing by 9, which gives ⌊4A/9⌋. The division by 9 becomes a multiply of the 17-bit address by an 18-bit reciprocal constant, ⌈2^21/9⌉ = 233017, followed by a right shift of 19. The product is at most 35 bits, so it fits a plain 18×18 multiplier. The remainder is then formed from shifts and a subtraction on the low five bits only.

The pipeline takes one address per clock and has two register stages. The first holds the product and the second holds the decoded results, which keeps each path short enough for a 100 MHz target.

Top module: `addr_div18_xlate`

## Requirements
- R1: For every byte address A from 0 to 2^17−1, the word index equals ⌊8·A/18⌋ (at most 58253).
- R2: The offset equals 8·A − 18·(word index). It is always in the range 0 to 17, and it is always even.
- R3: The straddle flag is 1 exactly when the offset is greater than 10. An offset of 10 does not straddle.
- R4: The first span equals the smaller of 8 and (18 − offset). The second span equals 8 minus the first span, so it is 0 when the byte does not straddle.
- R5: When an address is presented with in_valid high before rising edge k, out_valid is high after edge k+1 and the results belong to that address. A new address is accepted on every cycle, including back-to-back and gapped patterns.
- R6: While reset is asserted, and until a valid address has passed through both stages afterwards, out_valid is 0. Asserting reset clears the pipeline immediately, including when reset arrives in the middle of a stream.
- R7: When out_valid is 0, all result outputs hold the values of the most recent valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| in_valid | input | 1 | Marks in_addr as a request to translate this cycle |
| in_addr | input | 17 | Byte address |
| out_valid | output | 1 | Results on the outputs below are new this cycle |
| out_word | output | 16 | Index of the 18-bit word holding the byte's first bit |
| out_offset | output | 5 | Bit offset of the byte's first bit inside that word (0 to 17) |
| out_straddle | output | 1 | The byte continues into the next word |
| out_span_lo | output | 4 | Number of the byte's bits that lie in the first word |
| out_span_hi | output | 4 | Number of the byte's bits that lie in the following word |

## Verification
The assertions check the following on every cycle:
- The division identity 18·word + offset = 8·A, against the address captured two cycles earlier.
- The offset range and its evenness.
- The agreement between the straddle flag and the second span, and that the two spans sum to 8.
- That out_valid follows in_valid two edges later.
- That results hold while out_valid is low.

Only the bench scenarios show the following:
- That the quotient and remainder match a behavioural division for all 131072 addresses.
- That the exact boundary values come out right: an offset of 10 is not straddling, an offset of 16 is, and the largest address decodes correctly.
- That a reset arriving in the middle of a stream drops the work that was in flight.

// File: rtl/addr_div18_pkg.sv
package addr_div18_pkg;

  // Offset inside an 18-bit word (0..17) and span lengths (0..8).
  localparam int unsigned OFS_W  = 5;
  localparam int unsigned SPAN_W = 4;
  localparam int unsigned WORD_BITS = 18;
  localparam int unsigned BYTE_BITS = 8;
  // The byte straddles when its offset exceeds this value.
  localparam int unsigned LAST_FIT_OFS = WORD_BITS - BYTE_BITS;

  // Reciprocal of 9 scaled by 2^shift, rounded up.
  function automatic longint unsigned recip9(input int unsigned shift);
    return ((64'd1 << shift) + 64'd8) / 64'd9;
  endfunction

  typedef struct packed {
    logic              straddle;
    logic [OFS_W-1:0]  offset;
    logic [SPAN_W-1:0] span_lo;
    logic [SPAN_W-1:0] span_hi;
  } frag_t;

endpackage

// File: rtl/addr_div18_rst_sync.sv
module addr_div18_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_core_n = sync_q[1];

endmodule

// File: rtl/addr_div18_recip_mul.sv
// Stage 1: multiply the byte address by the scaled reciprocal of 9.
module addr_div18_recip_mul #(
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned MUL_W       = 18,
  parameter int unsigned RECIP_SHIFT = 21
) (
  input  logic                      clk,
  input  logic                      rst_core_n,
  input  logic                      in_valid,
  input  logic [ADDR_W-1:0]         in_addr,
  output logic                      s1_valid,
  output logic [ADDR_W+MUL_W-1:0]   s1_prod,
  output logic [1:0]                s1_addr_lo
);

  localparam int unsigned PROD_W = ADDR_W + MUL_W;
  localparam logic [MUL_W-1:0] MAGIC =
    MUL_W'(addr_div18_pkg::recip9(RECIP_SHIFT));

  logic [PROD_W-1:0] prod_d;
  logic              valid_d;
  logic              ce;

  always_comb begin
    prod_d  = PROD_W'(in_addr) * PROD_W'(MAGIC);
    valid_d = in_valid;
    ce      = in_valid;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ce) begin
      s1_prod    <= prod_d;
      s1_addr_lo <= in_addr[1:0];
    end
  end

endmodule

// File: rtl/addr_div18_span_calc.sv
// Combinational back end of stage 2: quotient extraction, remainder, spans.
module addr_div18_span_calc
  import addr_div18_pkg::*;
#(
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned MUL_W       = 18,
  parameter int unsigned RECIP_SHIFT = 21
) (
  input  logic [ADDR_W+MUL_W-1:0] prod,
  input  logic [1:0]              addr_lo,
  output logic [ADDR_W-2:0]       word,
  output frag_t                   frag
);

  localparam int unsigned WORD_W = ADDR_W - 1;
  // Quotient of (4A)/9 = (A*M) >> (RECIP_SHIFT-2)
  localparam int unsigned Q_SHR  = RECIP_SHIFT - 2;

  logic [OFS_W-1:0] pos_lo;
  logic [OFS_W-1:0] q16_lo;
  logic [OFS_W-1:0] q2_lo;
  logic [OFS_W-1:0] rem;
  logic             strad;

  always_comb begin
    word   = WORD_W'(prod >> Q_SHR);
    // Remainder is below 18, so five bits of each term suffice.
    pos_lo = {addr_lo, 3'b000};
    q16_lo = {word[0], 4'b0000};
    q2_lo  = {word[3:0], 1'b0};
    rem    = pos_lo - q16_lo - q2_lo;
    strad  = (rem > OFS_W'(LAST_FIT_OFS));
    frag.offset   = rem;
    frag.straddle = strad;
    frag.span_lo  = strad ? SPAN_W'(OFS_W'(WORD_BITS) - rem) : SPAN_W'(BYTE_BITS);
    frag.span_hi  = strad ? SPAN_W'(rem - OFS_W'(LAST_FIT_OFS)) : '0;
  end

endmodule

// File: rtl/addr_div18_xlate.sv
module addr_div18_xlate
  import addr_div18_pkg::*;
#(
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned MUL_W       = 18,
  parameter int unsigned RECIP_SHIFT = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  output logic [ADDR_W-2:0] out_word,
  output logic [4:0]        out_offset,
  output logic              out_straddle,
  output logic [3:0]        out_span_lo,
  output logic [3:0]        out_span_hi
);

  localparam int unsigned PROD_W = ADDR_W + MUL_W;
  localparam int unsigned WORD_W = ADDR_W - 1;

  logic              rst_core_n;
  logic              s1_valid;
  logic [PROD_W-1:0] s1_prod;
  logic [1:0]        s1_addr_lo;
  logic [WORD_W-1:0] word_d;
  frag_t             frag_d;
  logic [WORD_W-1:0] word_q;
  frag_t             frag_q;
  logic              valid_q;
  logic              ce2;

  addr_div18_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  addr_div18_recip_mul #(
    .ADDR_W      (ADDR_W),
    .MUL_W       (MUL_W),
    .RECIP_SHIFT (RECIP_SHIFT)
  ) u_recip_mul (
    .clk        (clk),
    .rst_core_n (rst_core_n),
    .in_valid   (in_valid),
    .in_addr    (in_addr),
    .s1_valid   (s1_valid),
    .s1_prod    (s1_prod),
    .s1_addr_lo (s1_addr_lo)
  );

  addr_div18_span_calc #(
    .ADDR_W      (ADDR_W),
    .MUL_W       (MUL_W),
    .RECIP_SHIFT (RECIP_SHIFT)
  ) u_span_calc (
    .prod    (s1_prod),
    .addr_lo (s1_addr_lo),
    .word    (word_d),
    .frag    (frag_d)
  );

  always_comb begin
    ce2 = s1_valid;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= s1_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (ce2) begin
      word_q <= word_d;
      frag_q <= frag_d;
    end
  end

  assign out_valid    = valid_q;
  assign out_word     = word_q;
  assign out_offset   = frag_q.offset;
  assign out_straddle = frag_q.straddle;
  assign out_span_lo  = frag_q.span_lo;
  assign out_span_hi  = frag_q.span_hi;

endmodule

// File: rtl/addr_div18_xlate_chk.sv
module addr_div18_xlate_chk #(
  parameter int unsigned ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              in_valid,
  input logic [ADDR_W-1:0] in_addr,
  input logic              out_valid,
  input logic [ADDR_W-2:0] out_word,
  input logic [4:0]        out_offset,
  input logic              out_straddle,
  input logic [3:0]        out_span_lo,
  input logic [3:0]        out_span_hi
);

  logic [ADDR_W-1:0] addr_d1, addr_d2;
  logic              vld_d1, vld_d2;
  logic              have_data;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      vld_d1    <= 1'b0;
      vld_d2    <= 1'b0;
      have_data <= 1'b0;
    end else begin
      vld_d1    <= in_valid;
      vld_d2    <= vld_d1;
      have_data <= have_data | out_valid;
    end
  end

  always_ff @(posedge clk) begin
    addr_d1 <= in_addr;
    addr_d2 <= addr_d1;
  end

  // R1, R2: division identity against the address two cycles back
  a_r1_div_identity: assert property (@(posedge clk) disable iff (!rst_core_n)
    out_valid |-> (32'(out_word) * 32'd18 + 32'(out_offset) == 32'(addr_d2) * 32'd8));

  a_r2_offset_range: assert property (@(posedge clk) disable iff (!rst_core_n)
    out_valid |-> (out_offset <= 5'd17 && out_offset[0] == 1'b0));

  a_r3_straddle_span: assert property (@(posedge clk) disable iff (!rst_core_n)
    out_valid |-> (out_straddle == (out_span_hi != 4'd0)));

  a_r4_span_sum: assert property (@(posedge clk) disable iff (!rst_core_n)
    out_valid |-> (out_span_lo + out_span_hi == 4'd8 && out_span_lo != 4'd0));

  a_r5_latency: assert property (@(posedge clk) disable iff (!rst_core_n)
    out_valid == vld_d2);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_core_n)
    (have_data && !out_valid) |-> ($stable(out_word) && $stable(out_offset) &&
      $stable(out_straddle) && $stable(out_span_lo) && $stable(out_span_hi)));

endmodule

bind addr_div18_xlate addr_div18_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_core_n   (rst_core_n),
  .in_valid     (in_valid),
  .in_addr      (in_addr),
  .out_valid    (out_valid),
  .out_word     (out_word),
  .out_offset   (out_offset),
  .out_straddle (out_straddle),
  .out_span_lo  (out_span_lo),
  .out_span_hi  (out_span_hi)
);

// File: tb/addr_div18_xlate_tb.sv
module addr_div18_xlate_tb;

  localparam int ADDR_W = 17;
  localparam int NADDR  = 1 << ADDR_W;

  logic              clk;
  logic              rst_n;
  logic              in_valid;
  logic [ADDR_W-1:0] in_addr;
  logic              out_valid;
  logic [ADDR_W-2:0] out_word;
  logic [4:0]        out_offset;
  logic              out_straddle;
  logic [3:0]        out_span_lo;
  logic [3:0]        out_span_hi;

  int checks = 0;
  int errors = 0;

  // expected pipeline
  bit p1_v, p2_v;
  int p1_a, p2_a;
  bit have_last;
  int last_a;

  addr_div18_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .out_valid(out_valid), .out_word(out_word), .out_offset(out_offset),
    .out_straddle(out_straddle), .out_span_lo(out_span_lo), .out_span_hi(out_span_hi)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_fields(input int a);
    int w, o, s1, s2;
    bit st;
    w  = (8 * a) / 18;
    o  = (8 * a) % 18;
    st = (o > 10);
    s1 = st ? 18 - o : 8;
    s2 = 8 - s1;
    chk(int'(out_word) == w, "R1", "word", int'(out_word), w);
    chk(int'(out_offset) == o, "R2", "offset", int'(out_offset), o);
    chk(out_straddle == st, "R3", "straddle", int'(out_straddle), int'(st));
    chk(int'(out_span_lo) == s1, "R4", "span_lo", int'(out_span_lo), s1);
    chk(int'(out_span_hi) == s2, "R4", "span_hi", int'(out_span_hi), s2);
  endtask

  // Sample results of the input driven two negedges ago, then drive new input.
  task automatic step(input bit v, input int a);
    chk(out_valid == p2_v, "R5", "out_valid", int'(out_valid), int'(p2_v));
    if (p2_v) begin
      check_fields(p2_a);
      have_last = 1'b1;
      last_a    = p2_a;
    end else if (have_last) begin
      // R7: outputs hold the last valid result
      check_fields(last_a);
    end
    p2_v = p1_v; p2_a = p1_a;
    p1_v = v;    p1_a = a;
    in_valid = v;
    in_addr  = ADDR_W'(a);
    @(negedge clk);
  endtask

  task automatic flush();
    repeat (3) step(1'b0, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_addr = '0;
    #1;
    chk(out_valid == 1'b0, "R6", "out_valid in reset", int'(out_valid), 0);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R6", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R6", "out_valid after reset", int'(out_valid), 0);
    p1_v = 0; p2_v = 0; have_last = 0;
  endtask

  task automatic t_boundaries();
    // offsets: 0 ->0, 1 ->8, 2 ->16 (straddle), 5 ->4, 4 ->14, 9 ->0, max ->14
    step(1'b1, 0);
    step(1'b1, 1);
    step(1'b1, 2);
    step(1'b1, 5);
    step(1'b1, 4);
    step(1'b1, 9);
    step(1'b1, 10);   // 80 bits: word 4 offset 8
    step(1'b1, 7);    // 56 bits: word 3 offset 2
    step(1'b1, NADDR - 1);
    flush();
  endtask

  task automatic t_gapped();
    for (int i = 0; i < 40; i++) begin
      step((i % 3) != 1, (i * 4099) % NADDR);
    end
    flush();
  endtask

  task automatic t_idle_hold();
    step(1'b1, 2);       // straddling result
    repeat (6) step(1'b0, 1234);  // R7: inputs change while in_valid is low
  endtask

  task automatic t_reset_midstream();
    step(1'b1, 100);
    step(1'b1, 101);
    rst_n = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R6", "out_valid on mid-stream reset", int'(out_valid), 0);
    do_reset();
    flush();
  endtask

  task automatic t_sweep();
    for (int a = 0; a < NADDR; a++) begin
      step(1'b1, a);
    end
    flush();
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_addr = '0;
    p1_v = 0; p2_v = 0; have_last = 0; p1_a = 0; p2_a = 0; last_a = 0;
    @(negedge clk);
    do_reset();
    t_boundaries();
    t_gapped();
    t_idle_hold();
    t_reset_midstream();
    t_sweep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule